// File: doc/BRIEF.md
# Wakeup Timer Count Register with Paired Half-Word Reload

This block keeps a free-running real-time count. A prescaler divides the input clock by `PRE_DIV`. Each time the prescaler reaches its terminal value, the count advances by one, provided counting is enabled.

Software sees the count through two half-word registers, one for the low half and one for the high half. Writing a half does not touch the count. The written value is held until the other half is also written, and the halves may arrive in either order. When the pair is complete, the whole count is loaded in a single step. At the same moment the prescaler restarts from zero, so later increments fall exactly on whole time units measured from the load. A one-cycle marker also announces that a new trim interval begins.

A status register shows which half, if any, is held and waiting for its twin. Reads of the count halves always return the live count.

Top module: `wut_pair_counter`

## Requirements
- R1: After reset the count is 0, counting is disabled, no half is held, the trim marker is low and every register reads 0.
- R2: The register address map is as follows. Address 0 is control, with bit 0 enabling counting. Address 1 holds count bits [15:0] and address 2 holds count bits [31:16]. Address 3 is status: bit 0 is set while a low half is held, and bit 1 is set while a high half is held. `reg_rdata_o` follows `reg_addr_i` combinationally and shows the live count.
- R3: While enabled, the count rises by exactly one every `PRE_DIV` clock cycles. While disabled, the count holds, and so does the prescaler's phase.
- R4: The count wraps from 0xFFFFFFFF to 0x00000000.
- R5: A write to only one half never changes the count. While that half waits, `pend_o` and its status bit read 1.
- R6: Once both halves have been written, in either order, the count shows {high, low} in the cycle after the completing write.
- R7: Writing the same half again before its twin arrives replaces the held value.
- R8: Completing a pair clears the prescaler, and no increment happens in that cycle. The first increment after a load comes exactly `PRE_DIV` cycles after the loaded value appears.
- R9: `trim_start_o` is high for exactly one cycle, the cycle in which a newly loaded count first appears.
- R10: A reload works whether counting is enabled or not. Completing a pair clears both status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for reads and writes |
| reg_wdata_i | input | BUS_W | Write data |
| reg_rdata_o | output | BUS_W | Read data for `reg_addr_i` |
| count_o | output | 2*BUS_W | Live count |
| pend_o | output | 1 | A half is held, waiting for its twin |
| trim_start_o | output | 1 | One-cycle marker that a new trim interval starts |

## Verification
Four properties are checked on every cycle:
- the count either holds or steps by one, except in the cycle a load appears;
- the count freezes while counting is disabled;
- at most one half is ever held;
- in the cycle a load appears, the trim marker is a single pulse, the prescaler is at zero and both status bits are clear.

The remaining behaviours need the bench's scenarios against a cycle model:
- the loaded value is exactly the two written halves;
- either order of writes gives the same result;
- a repeated half replaces the held value;
- the first increment after a load lands `PRE_DIV` cycles later.

// File: rtl/wut_pair_pkg.sv
package wut_pair_pkg;
   // Register addresses; the positions are part of the software contract.
   typedef enum logic [1:0] {
      RA_CTRL   = 2'd0,
      RA_CNT_LO = 2'd1,
      RA_CNT_HI = 2'd2,
      RA_STAT   = 2'd3
   } wut_reg_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int STAT_LO_BIT  = 0;
   localparam int STAT_HI_BIT  = 1;
   localparam int HALF_LO      = 0;
   localparam int HALF_HI      = 1;
endpackage

// File: rtl/wut_prescaler.sv
module wut_prescaler #(
   parameter int PRE_DIV = 32768,
   parameter int PRE_W   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clear_i,
   output logic             tick_o,
   output logic [PRE_W-1:0] pre_o
);
   generate
      if (PRE_DIV == 1) begin : g_bypass
         // Every enabled cycle is a whole unit; no phase state is needed.
         assign tick_o = run_i && !clear_i;
         assign pre_o  = '0;
      end else begin : g_divide
         localparam logic [PRE_W-1:0] TERM = PRE_W'(PRE_DIV - 1);
         logic [PRE_W-1:0] pre_q;

         assign tick_o = run_i && !clear_i && (pre_q == TERM);
         assign pre_o  = pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clear_i) begin
               pre_q <= '0;
            end else if (run_i) begin
               if (pre_q == TERM) pre_q <= '0;
               else               pre_q <= pre_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/wut_pair_hold.sv
module wut_pair_hold #(
   parameter int HALF_W = 16,
   localparam int FULL_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [HALF_W-1:0] wdata_i,
   output logic              commit_o,
   output logic [FULL_W-1:0] load_val_o,
   output logic              lo_pend_o,
   output logic              hi_pend_o
);
   import wut_pair_pkg::*;

   logic [1:0]              wr_h;
   logic [1:0]              pend_q;
   logic [1:0][HALF_W-1:0]  held_q;
   logic [1:0][HALF_W-1:0]  merged;

   assign wr_h[HALF_LO] = wr_lo_i;
   assign wr_h[HALF_HI] = wr_hi_i;

   // A write completes the pair when the opposite half is already waiting.
   assign commit_o = (wr_h[HALF_LO] && pend_q[HALF_HI]) ||
                     (wr_h[HALF_HI] && pend_q[HALF_LO]);

   always_comb begin
      for (int h = 0; h < 2; h++) begin
         merged[h] = wr_h[h] ? wdata_i : held_q[h];
      end
   end

   assign load_val_o = {merged[HALF_HI], merged[HALF_LO]};
   assign lo_pend_o  = pend_q[HALF_LO];
   assign hi_pend_o  = pend_q[HALF_HI];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         held_q <= '0;
      end else if (commit_o) begin
         pend_q <= '0;
      end else begin
         for (int h = 0; h < 2; h++) begin
            if (wr_h[h]) begin
               pend_q[h] <= 1'b1;
               held_q[h] <= wdata_i;
            end
         end
      end
   end
endmodule

// File: rtl/wut_count_core.sv
module wut_count_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             trim_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             trim_q;

   assign count_o = cnt_q;
   assign trim_o  = trim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trim_q <= 1'b0;
      end else begin
         trim_q <= load_i;
         // A software load takes precedence; no unit is added on that edge.
         if (load_i)      cnt_q <= load_val_i;
         else if (tick_i) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wut_pair_counter.sv
module wut_pair_counter #(
   parameter int BUS_W   = 16,
   parameter int PRE_DIV = 32768,
   localparam int CNT_W  = 2 * BUS_W,
   localparam int PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_i,
   input  logic [1:0]       reg_addr_i,
   input  logic [BUS_W-1:0] reg_wdata_i,
   output logic [BUS_W-1:0] reg_rdata_o,
   output logic [CNT_W-1:0] count_o,
   output logic             pend_o,
   output logic             trim_start_o
);
   import wut_pair_pkg::*;

   generate
      if (BUS_W < 2) begin : g_bad_bus
         $error("wut_pair_counter: BUS_W must be at least 2");
      end
      if (PRE_DIV < 1) begin : g_bad_div
         $error("wut_pair_counter: PRE_DIV must be at least 1");
      end
   endgenerate

   wut_reg_e         addr;
   logic             wr_ctrl, wr_lo, wr_hi;
   logic             ctrl_en;
   logic             commit;
   logic [CNT_W-1:0] load_val;
   logic             lo_pend, hi_pend;
   logic             tick;
   logic [PRE_W-1:0] pre_cnt;

   assign addr    = wut_reg_e'(reg_addr_i);
   assign wr_ctrl = reg_wr_i && (addr == RA_CTRL);
   assign wr_lo   = reg_wr_i && (addr == RA_CNT_LO);
   assign wr_hi   = reg_wr_i && (addr == RA_CNT_HI);

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_en <= 1'b0;
      else if (wr_ctrl) ctrl_en <= reg_wdata_i[CTRL_EN_BIT];
   end

   wut_pair_hold #(.HALF_W(BUS_W)) pair_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo_i    (wr_lo),
      .wr_hi_i    (wr_hi),
      .wdata_i    (reg_wdata_i),
      .commit_o   (commit),
      .load_val_o (load_val),
      .lo_pend_o  (lo_pend),
      .hi_pend_o  (hi_pend)
   );

   wut_prescaler #(.PRE_DIV(PRE_DIV), .PRE_W(PRE_W)) pre_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (ctrl_en),
      .clear_i (commit),
      .tick_o  (tick),
      .pre_o   (pre_cnt)
   );

   wut_count_core #(.CNT_W(CNT_W)) core_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .load_i     (commit),
      .load_val_i (load_val),
      .count_o    (count_o),
      .trim_o     (trim_start_o)
   );

   assign pend_o = lo_pend || hi_pend;

   always_comb begin
      reg_rdata_o = '0;
      unique case (addr)
         RA_CTRL:   reg_rdata_o[CTRL_EN_BIT] = ctrl_en;
         RA_CNT_LO: reg_rdata_o = count_o[BUS_W-1:0];
         RA_CNT_HI: reg_rdata_o = count_o[CNT_W-1:BUS_W];
         RA_STAT: begin
            reg_rdata_o[STAT_LO_BIT] = lo_pend;
            reg_rdata_o[STAT_HI_BIT] = hi_pend;
         end
         default:   reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/wut_pair_counter_chk.sv
module wut_pair_counter_chk #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_i,
   input logic             trim_i,
   input logic             commit_i,
   input logic             en_i,
   input logic             lo_pend_i,
   input logic             hi_pend_i,
   input logic [PRE_W-1:0] pre_i
);
   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trim_i |-> (count_i == $past(count_i) || count_i == $past(count_i) + 1'b1));

   // R3
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en_i) && !$past(commit_i)) |-> $stable(count_i));

   // R4
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(count_i) == {CNT_W{1'b1}} && !trim_i && count_i != $past(count_i))
      |-> count_i == '0);

   // R6
   single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lo_pend_i, hi_pend_i}));

   // R8
   pre_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trim_i |-> pre_i == '0);

   // R9
   trim_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> trim_i);

   // R9
   trim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trim_i |=> !trim_i);

   // R10
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trim_i |-> (!lo_pend_i && !hi_pend_i));
endmodule

bind wut_pair_counter wut_pair_counter_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .count_i   (count_o),
   .trim_i    (trim_start_o),
   .commit_i  (commit),
   .en_i      (ctrl_en),
   .lo_pend_i (lo_pend),
   .hi_pend_i (hi_pend),
   .pre_i     (pre_cnt)
);

// File: tb/wut_pair_counter_tb.sv
`timescale 1ns/1ps
module wut_pair_counter_tb_top;
   localparam int DIV = 5;
   localparam logic [1:0] A_CTRL = 2'd0, A_LO = 2'd1, A_HI = 2'd2, A_ST = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [31:0] count;
   logic        pend;
   logic        trim;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   logic [31:0] m_cnt;
   int          m_pre;
   bit          m_en, m_lo_p, m_hi_p, m_trim;
   logic [15:0] m_lo_h, m_hi_h;

   always #4 clk = ~clk;

   wut_pair_counter #(.BUS_W(16), .PRE_DIV(DIV)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr_i     (reg_wr),
      .reg_addr_i   (reg_addr),
      .reg_wdata_i  (reg_wdata),
      .reg_rdata_o  (reg_rdata),
      .count_o      (count),
      .pend_o       (pend),
      .trim_start_o (trim)
   );

   function automatic logic [15:0] exp_read(input logic [1:0] a);
      case (a)
         A_CTRL:  return {15'd0, m_en};
         A_LO:    return m_cnt[15:0];
         A_HI:    return m_cnt[31:16];
         default: return {14'd0, m_hi_p, m_lo_p};
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = '0; m_pre = 0; m_en = 0; m_lo_p = 0; m_hi_p = 0;
      m_trim = 0; m_lo_h = '0; m_hi_h = '0;
   endtask

   task automatic model_edge(input logic wr, input logic [1:0] a, input logic [15:0] d);
      bit commit;
      commit = wr && ((a == A_LO && m_hi_p) || (a == A_HI && m_lo_p));
      if (commit) begin
         m_cnt  = (a == A_LO) ? {m_hi_h, d} : {d, m_lo_h};
         m_pre  = 0;
         m_lo_p = 0;
         m_hi_p = 0;
         m_trim = 1;
      end else begin
         m_trim = 0;
         if (m_en) begin
            if (m_pre == DIV - 1) begin m_pre = 0; m_cnt = m_cnt + 1; end
            else m_pre = m_pre + 1;
         end
         if (wr && a == A_LO) begin m_lo_p = 1; m_lo_h = d; end
         if (wr && a == A_HI) begin m_hi_p = 1; m_hi_h = d; end
      end
      if (wr && a == A_CTRL) m_en = d[0];
   endtask

   // One clock: drive at the falling edge, update the model at the rising edge, compare just after.
   task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      model_edge(wr, a, d);
      #1;
      chk("R3/R6 count", count, m_cnt);
      chk("R9 trim", {31'd0, trim}, {31'd0, m_trim});
      chk("R5 pend", {31'd0, pend}, {31'd0, (m_lo_p || m_hi_p)});
      chk("R2 rdata", {16'd0, reg_rdata}, {16'd0, exp_read(a)});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, A_ST, 16'h0);
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd24681));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state through every register
      for (int a = 0; a < 4; a++) begin
         step(1'b0, 2'(a), 16'h0);
         chk("R1 reset read", {16'd0, reg_rdata}, 32'd0);
      end
      chk("R1 reset count", count, 32'd0);

      // R3: enable and count
      step(1'b1, A_CTRL, 16'h1);
      idle(3 * DIV);
      chk("R3 three units", count, 32'd3);

      // R5: lone low write leaves the count alone
      v = count;
      step(1'b1, A_LO, 16'h1234);
      idle(DIV + 1);
      chk("R5 lone write", count, v + 1);
      step(1'b0, A_ST, 16'h0);
      chk("R5 status low held", {16'd0, reg_rdata}, 32'd1);

      // R7: rewrite low, then high completes
      step(1'b1, A_LO, 16'h5678);
      step(1'b1, A_HI, 16'h00AB);
      chk("R7 replaced low", count, 32'h00AB_5678);
      chk("R9 trim on load", {31'd0, trim}, 32'd1);

      // R8: first increment exactly DIV cycles later
      idle(DIV - 1);
      chk("R8 no early tick", count, 32'h00AB_5678);
      idle(1);
      chk("R8 tick on time", count, 32'h00AB_5679);

      // R6: high first, then low
      step(1'b1, A_HI, 16'hFFFF);
      step(1'b0, A_ST, 16'h0);
      chk("R6 status high held", {16'd0, reg_rdata}, 32'd2);
      step(1'b1, A_LO, 16'hFFFF);
      chk("R6 high-first load", count, 32'hFFFF_FFFF);

      // R4: wrap
      idle(DIV);
      chk("R4 wrap", count, 32'h0);

      // R10: reload with counting disabled
      step(1'b1, A_CTRL, 16'h0);
      step(1'b1, A_LO, 16'hBEEF);
      step(1'b1, A_HI, 16'hDEAD);
      chk("R10 disabled load", count, 32'hDEAD_BEEF);
      step(1'b0, A_ST, 16'h0);
      chk("R10 status clear", {16'd0, reg_rdata}, 32'd0);
      idle(2 * DIV);
      chk("R3 disabled hold", count, 32'hDEAD_BEEF);
      step(1'b1, A_CTRL, 16'h1);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom % 16);
         if (r < 2)       step(1'b1, A_LO, 16'($urandom));
         else if (r < 4)  step(1'b1, A_HI, 16'($urandom));
         else if (r == 4) step(1'b1, A_CTRL, {15'd0, ($urandom % 4) != 0});
         else             step(1'b0, 2'($urandom % 4), 16'($urandom));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule